// File: doc/BRIEF.md
# Reserved-Address Command Sequencer for a Two-Wire Slave

This block runs beside the byte-level datapath of a two-wire (I2C) slave and handles the command sequences that use reserved addresses rather than the normal memory address. Two sequences share a common opening. After START the master sends the prefix code F8h. The next byte must carry this device's 7-bit address. After a repeated START a second code then picks what happens. F9h reads out a three-byte identification word. 86h arms sleep, and the device enters sleep on the STOP that follows.

The shifter reports decoded bus events to the block: START, STOP, a received byte, and the master's ACK or NACK after a byte the slave transmitted. The block answers with a registered reply strobe that says ACK or NACK for each byte it claims. It supplies the identification byte to transmit, and it raises an override flag so that the memory path leaves these bytes alone.

While asleep the block keeps watching the bus. A START followed by this device's own address starts a recovery interval that is counted in system clock cycles. During recovery, and all through sleep, the block holds a flag that tells the datapath to NACK every address. The flag drops once the interval has run out.

Top module: `rsvid_seq`

## Requirements
- R1: After reset, ackStb, txValid, overrideOut, sleepOut and busyNack are all low.
- R2: When F8h is the first byte after a START, the block replies ACK and enters the prefix phase. A byte that is not the first after a START, or any first byte other than F8h, gets no reply at all.
- R3: In the prefix phase, bits 7:1 of the next byte are compared with devAddr and bit 0 is ignored. On a match the block replies ACK. On a mismatch it replies NACK and returns to idle.
- R4: After a matching address, a repeated START and then F9h get an ACK and begin the identification readout. txValid goes high, and txData presents the bytes 00h, 41h, 00h in that order. These bytes come from the 24-bit word {12-bit maker field, 9-bit product field, 3-bit revision field}, most significant byte first.
- R5: During the readout a master ACK moves txData to the next byte. A master NACK ends the readout, as does an ACK on the last byte, and txValid and overrideOut then drop.
- R6: After a matching address, a repeated START and then 86h get an ACK and arm sleep. The next STOP raises sleepOut. A START in its place cancels the arming.
- R7: The sequence is abandoned, with a NACK reply where a byte caused it, in three cases: a STOP anywhere inside it, a byte after the address that arrives without a repeated START, or a second code other than F9h or 86h.
- R8: While asleep, busyNack is high and the block sends no reply to any byte. Non-matching addresses and the F8h prefix leave it asleep.
- R9: A START followed by a byte whose bits 7:1 equal devAddr wakes the block. sleepOut drops, and busyNack stays high for exactly WAKE_CYC clock cycles after the edge that took in that byte, then falls. Sequences are accepted again after that.
- R10: overrideOut is high from the clock edge after the accepted F8h until the sequence ends, and it is never high together with busyNack.
- R11: Each reply appears on ackStb as a one-cycle pulse in the cycle that follows the evByte strobe it answers, with ackVal set to 1 for ACK and 0 for NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| devAddr | input | 7 | This device's 7-bit bus address |
| evStart | input | 1 | One-cycle strobe: START or repeated START seen |
| evStop | input | 1 | One-cycle strobe: STOP seen |
| evByte | input | 1 | One-cycle strobe: a byte has been received |
| rxByte | input | 8 | Received byte, valid with evByte |
| evMack | input | 1 | One-cycle strobe: master acknowledge slot after a transmitted byte |
| mackAck | input | 1 | With evMack: 1 = master ACK, 0 = master NACK |
| ackStb | output | 1 | Reply strobe for a byte the block claims |
| ackVal | output | 1 | Reply value with ackStb: 1 = ACK, 0 = NACK |
| txValid | output | 1 | Identification byte on txData is to be transmitted |
| txData | output | 8 | Identification byte to transmit |
| overrideOut | output | 1 | Memory datapath must ignore the current bytes |
| sleepOut | output | 1 | Device is in sleep |
| busyNack | output | 1 | Datapath must NACK all addresses (sleep or recovery) |

## Verification
The bound checker tests invariants on every cycle. A reply never appears without a received byte in the cycle before it, and no reply appears while busyNack is high. txValid only appears under the override, the override and busyNack are never both high, sleep begins only on a STOP, and waking always passes through recovery. Other properties need a complete bus scenario, so only the bench's scenarios can show them. These are the byte order of the identification word, the exact length of the recovery interval, the rule that bit 0 of the address does not matter, and the rejection of the different malformed prefixes.

// File: rtl/rsvid_pkg.sv
package rsvid_pkg;

  localparam logic [7:0] CODE_PREFIX = 8'hF8;
  localparam logic [7:0] CODE_IDREAD = 8'hF9;
  localparam logic [7:0] CODE_SLEEP  = 8'h86;

  localparam int MAKER_W = 12;
  localparam int PROD_W  = 9;
  localparam int REV_W   = 3;
  localparam int IDW_W   = MAKER_W + PROD_W + REV_W;
  localparam int ID_BYTES = IDW_W / 8;
  localparam int IDX_W   = $clog2(ID_BYTES);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PREFIX,   // F8h accepted, waiting for address byte
    ST_MATCHED,  // own address accepted, waiting for repeated START
    ST_SELECT,   // repeated START seen, waiting for second code
    ST_IDREAD,   // transmitting identification bytes
    ST_ARMED,    // sleep armed, waiting for STOP
    ST_SLEEP,
    ST_SLPADR,   // START seen while asleep, waiting for address
    ST_WAKE      // recovery interval running
  } seq_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic idClr;
    logic idAdv;
    logic wakeLoad;
  } seq_strb_t;

endpackage

// File: rtl/rsvid_dp.sv
module rsvid_dp
  import rsvid_pkg::*;
#(
  parameter logic [MAKER_W-1:0] MAKER_ID = 12'h004,
  parameter logic [PROD_W-1:0]  PROD_ID  = 9'h020,
  parameter logic [REV_W-1:0]   REV_ID   = 3'h0,
  parameter int WAKE_CYC = 20000
) (
  input  logic            clk,
  input  logic            rstN,
  input  seq_strb_t       strb,
  output logic [7:0]      idByte,
  output logic            idLast,
  output logic            wakeDone
);

  localparam logic [IDW_W-1:0] ID_WORD = {MAKER_ID, PROD_ID, REV_ID};
  localparam int CNT_W = $clog2(WAKE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAKE_CYC - 1);

  logic [7:0] idTable [ID_BYTES];

  // byte k of the word, most significant byte first
  for (genvar g = 0; g < ID_BYTES; g++) begin : g_idbyte
    assign idTable[g] = ID_WORD[IDW_W-1-8*g -: 8];
  end

  logic [IDX_W-1:0] idIdx;
  logic [CNT_W-1:0] wakeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idIdx <= '0;
    end else if (strb.idClr) begin
      idIdx <= '0;
    end else if (strb.idAdv && !idLast) begin
      idIdx <= idIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCnt <= '0;
    end else if (strb.wakeLoad) begin
      wakeCnt <= CNT_LOAD;
    end else if (wakeCnt != '0) begin
      wakeCnt <= wakeCnt - 1'b1;
    end
  end

  assign idByte   = idTable[idIdx];
  assign idLast   = (idIdx == IDX_W'(ID_BYTES - 1));
  assign wakeDone = (wakeCnt == '0);

endmodule

// File: rtl/rsvid_ctrl.sv
module rsvid_ctrl
  import rsvid_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [6:0] devAddr,
  input  logic       evStart,
  input  logic       evStop,
  input  logic       evByte,
  input  logic [7:0] rxByte,
  input  logic       evMack,
  input  logic       mackAck,
  input  logic       idLast,
  input  logic       wakeDone,
  output seq_strb_t  strb,
  output logic       ackStb,
  output logic       ackVal,
  output logic       txValid,
  output logic       overrideOut,
  output logic       sleepOut,
  output logic       busyNack
);

  seq_state_t state, stateNxt;
  logic firstByte;
  logic replyNow, replyAck;
  logic addrHit;

  assign addrHit = (rxByte[7:1] == devAddr);

  always_comb begin
    stateNxt = state;
    replyNow = 1'b0;
    replyAck = 1'b0;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (evByte && firstByte && rxByte == CODE_PREFIX) begin
          stateNxt = ST_PREFIX;
          replyNow = 1'b1;
          replyAck = 1'b1;
        end
      end
      ST_PREFIX: begin
        if (evStart || evStop) begin
          stateNxt = ST_IDLE;
        end else if (evByte) begin
          replyNow = 1'b1;
          replyAck = addrHit;
          stateNxt = addrHit ? ST_MATCHED : ST_IDLE;
        end
      end
      ST_MATCHED: begin
        if (evStart) begin
          stateNxt = ST_SELECT;
        end else if (evStop) begin
          stateNxt = ST_IDLE;
        end else if (evByte) begin
          replyNow = 1'b1;
          stateNxt = ST_IDLE;
        end
      end
      ST_SELECT: begin
        if (evStart || evStop) begin
          stateNxt = ST_IDLE;
        end else if (evByte) begin
          replyNow = 1'b1;
          if (rxByte == CODE_IDREAD) begin
            replyAck   = 1'b1;
            strb.idClr = 1'b1;
            stateNxt   = ST_IDREAD;
          end else if (rxByte == CODE_SLEEP) begin
            replyAck = 1'b1;
            stateNxt = ST_ARMED;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
      end
      ST_IDREAD: begin
        if (evStart || evStop) begin
          stateNxt = ST_IDLE;
        end else if (evMack) begin
          if (mackAck && !idLast) begin
            strb.idAdv = 1'b1;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
      end
      ST_ARMED: begin
        if (evStop) begin
          stateNxt = ST_SLEEP;
        end else if (evStart || evByte) begin
          stateNxt = ST_IDLE;
        end
      end
      ST_SLEEP: begin
        if (evStart) stateNxt = ST_SLPADR;
      end
      ST_SLPADR: begin
        if (evStop) begin
          stateNxt = ST_SLEEP;
        end else if (evByte) begin
          if (addrHit) begin
            strb.wakeLoad = 1'b1;
            stateNxt      = ST_WAKE;
          end else begin
            stateNxt = ST_SLEEP;
          end
        end
      end
      ST_WAKE: begin
        if (wakeDone) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      firstByte <= 1'b0;
      ackStb    <= 1'b0;
      ackVal    <= 1'b0;
    end else begin
      state  <= stateNxt;
      ackStb <= replyNow;
      ackVal <= replyAck;
      if (evStart) begin
        firstByte <= 1'b1;
      end else if (evByte || evStop) begin
        firstByte <= 1'b0;
      end
    end
  end

  assign txValid     = (state == ST_IDREAD);
  assign overrideOut = (state == ST_PREFIX) || (state == ST_MATCHED) ||
                       (state == ST_SELECT) || (state == ST_IDREAD) ||
                       (state == ST_ARMED);
  assign sleepOut    = (state == ST_SLEEP) || (state == ST_SLPADR);
  assign busyNack    = sleepOut || (state == ST_WAKE);

endmodule

// File: rtl/rsvid_seq.sv
module rsvid_seq
  import rsvid_pkg::*;
#(
  parameter logic [MAKER_W-1:0] MAKER_ID = 12'h004,
  parameter logic [PROD_W-1:0]  PROD_ID  = 9'h020,
  parameter logic [REV_W-1:0]   REV_ID   = 3'h0,
  parameter int CLK_MHZ = 50,
  parameter int WAKE_US = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [6:0] devAddr,
  input  logic       evStart,
  input  logic       evStop,
  input  logic       evByte,
  input  logic [7:0] rxByte,
  input  logic       evMack,
  input  logic       mackAck,
  output logic       ackStb,
  output logic       ackVal,
  output logic       txValid,
  output logic [7:0] txData,
  output logic       overrideOut,
  output logic       sleepOut,
  output logic       busyNack
);

  localparam int WAKE_CYC = CLK_MHZ * WAKE_US;

  seq_strb_t strb;
  logic idLast;
  logic wakeDone;
  logic [7:0] idByte;

  rsvid_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .devAddr(devAddr),
    .evStart(evStart), .evStop(evStop), .evByte(evByte), .rxByte(rxByte),
    .evMack(evMack), .mackAck(mackAck),
    .idLast(idLast), .wakeDone(wakeDone),
    .strb(strb), .ackStb(ackStb), .ackVal(ackVal), .txValid(txValid),
    .overrideOut(overrideOut), .sleepOut(sleepOut), .busyNack(busyNack)
  );

  rsvid_dp #(
    .MAKER_ID(MAKER_ID), .PROD_ID(PROD_ID), .REV_ID(REV_ID),
    .WAKE_CYC(WAKE_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .idByte(idByte), .idLast(idLast), .wakeDone(wakeDone)
  );

  assign txData = txValid ? idByte : 8'h00;

endmodule

// File: rtl/rsvid_seq_chk.sv
module rsvid_seq_chk (
  input logic clk,
  input logic rstN,
  input logic evByte,
  input logic evStop,
  input logic ackStb,
  input logic txValid,
  input logic overrideOut,
  input logic sleepOut,
  input logic busyNack
);

  // R11: a reply only follows a received byte
  p_reply_after_byte_r11: assert property (@(posedge clk) disable iff (!rstN)
    ackStb |-> $past(evByte));

  // R8: no reply while the block forces NACKs
  p_silent_when_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busyNack |-> !ackStb);

  // R8: sleep always implies the NACK-all flag
  p_sleep_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    sleepOut |-> busyNack);

  // R10: transmit only inside an overridden sequence
  p_tx_in_override_r10: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> overrideOut);

  // R10: override and NACK-all are exclusive
  p_override_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(overrideOut && busyNack));

  // R6: sleep starts only on a STOP
  p_sleep_on_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepOut) |-> $past(evStop));

  // R9: leaving sleep enters recovery
  p_wake_recovery_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepOut) |-> busyNack);

endmodule

bind rsvid_seq rsvid_seq_chk u_chk (.*);

// File: tb/test_rsvid_seq.sv
module test_rsvid_seq;

  localparam int WAKE_N = 50;   // CLK_MHZ 50 * WAKE_US 1
  localparam logic [6:0] MYADDR = 7'h52;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] devAddr = MYADDR;
  logic evStart = 1'b0, evStop = 1'b0, evByte = 1'b0, evMack = 1'b0, mackAck = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic ackStb, ackVal, txValid, overrideOut, sleepOut, busyNack;
  logic [7:0] txData;

  int checks = 0;
  int errors = 0;
  bit expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  rsvid_seq #(.CLK_MHZ(50), .WAKE_US(1)) i_rsvid_seq (
    .clk(clk), .rstN(rstN), .devAddr(devAddr),
    .evStart(evStart), .evStop(evStop), .evByte(evByte), .rxByte(rxByte),
    .evMack(evMack), .mackAck(mackAck),
    .ackStb(ackStb), .ackVal(ackVal), .txValid(txValid), .txData(txData),
    .overrideOut(overrideOut), .sleepOut(sleepOut), .busyNack(busyNack)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every reply is compared with the queued expectation
  always @(negedge clk) begin
    if (rstN && ackStb) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11 unexpected reply", 1, 0);
      end else begin
        automatic bit e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(ackVal == e, t, ackVal, e);
      end
    end
  end

  task automatic pulseStart();
    @(negedge clk) evStart = 1'b1;
    @(negedge clk) evStart = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk) evStop = 1'b1;
    @(negedge clk) evStop = 1'b0;
  endtask

  // kind: 0 no reply expected, 1 ACK, 2 NACK
  task automatic sendByte(input logic [7:0] b, input int kind, input string tag);
    if (kind != 0) begin
      expQ.push_back(kind == 1);
      tagQ.push_back(tag);
    end
    @(negedge clk) begin evByte = 1'b1; rxByte = b; end
    @(negedge clk) evByte = 1'b0;
  endtask

  task automatic masterAck(input bit a);
    @(negedge clk) begin evMack = 1'b1; mackAck = a; end
    @(negedge clk) evMack = 1'b0;
  endtask

  task automatic prefix(input bit rw);
    pulseStart();
    sendByte(8'hF8, 1, "R2 prefix ACK");
    sendByte({MYADDR, rw}, 1, "R3 own address ACK");
    pulseStart();
  endtask

  task automatic drainCheck(input string tag);
    @(negedge clk);
    check(expQ.size() == 0, tag, expQ.size(), 0);
    expQ.delete(); tagQ.delete();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ackStb == 0 && txValid == 0 && overrideOut == 0 && sleepOut == 0 && busyNack == 0,
          "R1 reset outputs", {ackStb, txValid, overrideOut, sleepOut, busyNack}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4/R5: full readout, address bit 0 set (don't-care)
    prefix(1'b1);
    sendByte(8'hF9, 1, "R4 readout code ACK");
    check(overrideOut == 1, "R10 override in readout", overrideOut, 1);
    check(txValid == 1 && txData == 8'h00, "R4 id byte0", txData, 8'h00);
    masterAck(1'b1);
    check(txData == 8'h41, "R4 id byte1", txData, 8'h41);
    masterAck(1'b1);
    check(txData == 8'h00 && txValid == 1, "R4 id byte2", txData, 8'h00);
    masterAck(1'b0);
    check(txValid == 0 && overrideOut == 0, "R5 NACK ends readout", {txValid, overrideOut}, 0);
    pulseStop();
    drainCheck("R4 replies complete");

    // R5: NACK on first byte ends; address bit 0 clear
    prefix(1'b0);
    sendByte(8'hF9, 1, "R4 readout code ACK");
    masterAck(1'b0);
    check(txValid == 0, "R5 early NACK", txValid, 0);
    // R5: ACK on last byte also ends
    prefix(1'b0);
    sendByte(8'hF9, 1, "R4 readout code ACK");
    masterAck(1'b1); masterAck(1'b1); masterAck(1'b1);
    check(overrideOut == 0, "R5 ACK on last byte ends", overrideOut, 0);
    pulseStop();
    drainCheck("R5 replies complete");

    // R3: mismatching address
    pulseStart();
    sendByte(8'hF8, 1, "R2 prefix ACK");
    check(overrideOut == 1, "R10 override after prefix", overrideOut, 1);
    sendByte({7'h13, 1'b0}, 2, "R3 foreign address NACK");
    check(overrideOut == 0, "R3 idle after mismatch", overrideOut, 0);
    pulseStop();

    // R2: F8h not first after START gets no reply
    pulseStart();
    sendByte(8'hA0, 0, "");
    sendByte(8'hF8, 0, "");
    check(overrideOut == 0, "R2 late F8 ignored", overrideOut, 0);
    pulseStop();
    drainCheck("R2 no stray reply");

    // R7: bad second code, missing repeated START, STOP mid-sequence
    prefix(1'b0);
    sendByte(8'h55, 2, "R7 bad second code NACK");
    check(overrideOut == 0, "R7 idle after bad code", overrideOut, 0);
    pulseStop();
    pulseStart();
    sendByte(8'hF8, 1, "R2 prefix ACK");
    sendByte({MYADDR, 1'b0}, 1, "R3 own address ACK");
    sendByte(8'hF9, 2, "R7 code without repeated START NACK");
    check(txValid == 0, "R7 no readout without Sr", txValid, 0);
    pulseStop();
    pulseStart();
    sendByte(8'hF8, 1, "R2 prefix ACK");
    pulseStop();
    check(overrideOut == 0, "R7 STOP aborts", overrideOut, 0);
    drainCheck("R7 replies complete");

    // R6: arming cancelled by START
    prefix(1'b0);
    sendByte(8'h86, 1, "R6 sleep code ACK");
    check(sleepOut == 0, "R6 not asleep before STOP", sleepOut, 0);
    pulseStart();
    pulseStop();
    check(sleepOut == 0, "R6 START cancels arming", sleepOut, 0);

    // R6: sleep entry
    prefix(1'b0);
    sendByte(8'h86, 1, "R6 sleep code ACK");
    pulseStop();
    check(sleepOut == 1 && busyNack == 1, "R6 asleep after STOP", {sleepOut, busyNack}, 3);

    // R8: ignored bytes while asleep
    pulseStart();
    sendByte({7'h13, 1'b0}, 0, "");
    check(sleepOut == 1, "R8 foreign address keeps sleep", sleepOut, 1);
    pulseStart();
    sendByte(8'hF8, 0, "");
    check(sleepOut == 1 && overrideOut == 0, "R8 prefix ignored asleep", {sleepOut, overrideOut}, 2);
    pulseStop();
    drainCheck("R8 no reply asleep");

    // R9: wake and measure recovery length
    pulseStart();
    sendByte({MYADDR, 1'b1}, 0, "");
    check(sleepOut == 0, "R9 sleep drops on own address", sleepOut, 0);
    begin
      int c = 0;
      while (busyNack && c < WAKE_N + 10) begin
        c++;
        @(negedge clk);
      end
      check(c == WAKE_N, "R9 recovery length", c, WAKE_N);
    end
    pulseStop();

    // R9: sequences accepted after recovery
    prefix(1'b0);
    sendByte(8'hF9, 1, "R9 readout after wake");
    check(txValid == 1 && txData == 8'h00, "R9 readout works after wake", txData, 0);
    masterAck(1'b0);
    pulseStop();
    drainCheck("R9 replies complete");

    // R8/R10: prefix during recovery ignored
    prefix(1'b0);
    sendByte(8'h86, 1, "R6 sleep code ACK");
    pulseStop();
    pulseStart();
    sendByte({MYADDR, 1'b0}, 0, "");
    pulseStart();
    sendByte(8'hF8, 0, "");
    check(busyNack == 1 && overrideOut == 0, "R8 prefix ignored in recovery", {busyNack, overrideOut}, 2);
    repeat (WAKE_N + 5) @(negedge clk);
    check(busyNack == 0, "R9 recovery ends", busyNack, 0);
    drainCheck("R8 no reply in recovery");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule